// File: doc/BRIEF.md
# Reset and Power-Down Mute Sequencer

This controller brings a data converter from hardware reset into active operation. While the active-low reset input is held low, the converter is kept in low-power mode with its outputs muted, and all sequencer state is cleared. Releasing reset makes the control registers writable, but the converter stays in low power. It leaves low power only when software clears the power-down bit.

Clearing the power-down bit starts a reference-ramp interval. During this interval the analog section is powered, but both the serial data output and the converter outputs stay muted. The length of the interval is a cycle count taken from a settle-count input at the moment the bit is cleared. This interval stands in for the slow reference settling, which takes far longer than modulator settling. When the count is used up, the outputs unmute.

Setting the power-down bit again, or pulling reset low, sends the converter straight back to a muted low-power state.

Top module: `pwr_mute_seq`

## Requirements
- R1: While rst_n is low, state_o is 0 (hold), lowpwr_o is 1 and mute_o is 1, with no clock edge needed.
- R2: On the first rising edge after rst_n goes high, state_o becomes 1 (standby). While pdn_i stays 1, it stays 1 with lowpwr_o=1 and mute_o=1.
- R3: In standby, a rising edge that samples pdn_i=0 moves state_o to 2 (settling) and captures settle_cnt_i as N. From that edge on, lowpwr_o is 0.
- R4: mute_o stays 1 for the whole settling state. Changes on settle_cnt_i after the capture do not alter the interval.
- R5: State 3 (run) is entered on the (N+1)th rising edge after the edge that entered settling. In run, with pdn_i=0, mute_o=0 and lowpwr_o=0.
- R6: pdn_i=1 in settling or run sets lowpwr_o and mute_o to 1 at once. The next rising edge returns state_o to 1. Clearing pdn_i again starts a fresh interval of the full new count.
- R7: rst_n going low in any state forces state_o to 0 with lowpwr_o=1 and mute_o=1 at once, without a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hardware reset, active low, asynchronous |
| pdn_i | input | 1 | Power-down control bit, 1 = stay in low power |
| settle_cnt_i | input | CNT_W | Reference-ramp length in cycles, captured when pdn_i is cleared |
| lowpwr_o | output | 1 | 1 = converter in low-power mode |
| mute_o | output | 1 | 1 = serial data and converter outputs muted |
| state_o | output | 2 | 0 hold, 1 standby, 2 settling, 3 run |

## Verification
The bench builds the block with CNT_W=5. This puts every settle count from 0 to 31 within a short run, so each interval length is swept exhaustively against the arithmetic N+1 edge count. For every count, the bench also exercises an exit from run. Depending on the count, that exit is a power-down request, an asynchronous reset, or none. A separate pass aborts a settling interval part-way and checks that the next interval restarts from the full count.

// File: rtl/pwr_mute_seq.sv
module pwr_mute_seq #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pdn_i,
  input  logic [CNT_W-1:0] settle_cnt_i,
  output logic             lowpwr_o,
  output logic             mute_o,
  output logic [1:0]       state_o
);

  typedef enum logic [1:0] {S_HOLD = 2'd0, S_STBY = 2'd1, S_SETTLE = 2'd2, S_RUN = 2'd3} st_t;

  st_t             st, st_nx;
  logic [CNT_W-1:0] cnt, cnt_nx;

  always_comb begin
    st_nx  = st;
    cnt_nx = cnt;
    case (st)
      S_HOLD: st_nx = S_STBY;
      S_STBY: if (!pdn_i) begin
        st_nx  = S_SETTLE;
        cnt_nx = settle_cnt_i;
      end
      S_SETTLE: begin
        if (pdn_i)            st_nx = S_STBY;
        else if (cnt == '0)   st_nx = S_RUN;
        else                  cnt_nx = cnt - 1'b1;
      end
      S_RUN: if (pdn_i) st_nx = S_STBY;
      default: st_nx = S_HOLD;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_HOLD;
      cnt <= '0;
    end else begin
      st  <= st_nx;
      cnt <= cnt_nx;
    end
  end

  assign state_o  = st;
  assign lowpwr_o = !rst_n || pdn_i || st == S_HOLD || st == S_STBY;
  assign mute_o   = !(rst_n && st == S_RUN && !pdn_i);

  a_r2_standby_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_STBY && pdn_i) |=> st == S_STBY);
  a_r3_settle_load: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_STBY && !pdn_i) |=> (st == S_SETTLE && cnt == $past(settle_cnt_i)));
  a_r4_muted_settling: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_SETTLE |-> mute_o);
  a_r5_no_early_run: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SETTLE && !pdn_i && cnt != '0) |=> (st == S_SETTLE && cnt == $past(cnt) - 1'b1));
  a_r6_pdn_exit: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == S_RUN || st == S_SETTLE) && pdn_i) |=> st == S_STBY);

endmodule

// File: tb/pwr_mute_seq_test.sv
module pwr_mute_seq_test;
  localparam int W = 5;
  logic clk = 0, rst_n = 0, pdn = 1;
  logic [W-1:0] scnt = '0;
  logic lp, mu;
  logic [1:0] st;
  int tests = 0, fails = 0, cyc = 0;

  pwr_mute_seq #(.CNT_W(W)) uut (.clk(clk), .rst_n(rst_n), .pdn_i(pdn),
    .settle_cnt_i(scnt), .lowpwr_o(lp), .mute_o(mu), .state_o(st));

  always #5 clk = ~clk;

  task automatic chk(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_all(string req, int es, int elp, int emu);
    chk({req, " state"}, st, es);
    chk({req, " lowpwr"}, lp, elp);
    chk({req, " mute"}, mu, emu);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        fails++; tests++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    end
  end

  initial begin
    for (int n = 0; n < 32; n++) begin
      @(negedge clk);
      rst_n = 0; pdn = 1; scnt = W'(n);
      #1 chk_all("R1 reset", 0, 1, 1);
      @(negedge clk); chk_all("R1 reset held", 0, 1, 1);
      rst_n = 1;
      @(negedge clk); chk_all("R2 standby", 1, 1, 1);
      @(negedge clk); chk_all("R2 standby pdn=1", 1, 1, 1);
      pdn = 0;
      for (int k = 1; k <= n + 1; k++) begin
        @(negedge clk);
        if (k == 1) scnt = ~W'(n);
        chk_all(k == 1 ? "R3 settle entry" : "R4 settling muted", 2, 0, 1);
      end
      @(negedge clk); chk_all("R5 run", 3, 0, 0);
      @(negedge clk); chk_all("R5 run stays", 3, 0, 0);
      if (n % 3 == 0) begin
        pdn = 1;
        #1 chk_all("R6 pdn in run immediate", 3, 1, 1);
        @(negedge clk); chk_all("R6 back to standby", 1, 1, 1);
      end else if (n % 3 == 1) begin
        rst_n = 0;
        #1 chk_all("R7 async reset from run", 0, 1, 1);
      end
    end

    for (int n = 2; n < 32; n += 7) begin
      @(negedge clk);
      rst_n = 0; pdn = 1; scnt = W'(n);
      @(negedge clk); rst_n = 1;
      @(negedge clk); pdn = 0;
      @(negedge clk); @(negedge clk);
      chk_all("R4 mid settle", 2, 0, 1);
      pdn = 1;
      #1 chk_all("R6 pdn in settle immediate", 2, 1, 1);
      @(negedge clk); chk_all("R6 abort to standby", 1, 1, 1);
      pdn = 0;
      for (int k = 1; k <= n + 1; k++) begin
        @(negedge clk);
        chk_all("R6 fresh interval", 2, 0, 1);
      end
      @(negedge clk); chk_all("R6 fresh run", 3, 0, 0);
      @(negedge clk); @(negedge clk);
      rst_n = 0; pdn = 0;
      #1 chk_all("R7 reset with pdn clear", 0, 1, 1);
      @(negedge clk); chk_all("R7 held in reset", 0, 1, 1);
    end

    @(negedge clk);
    rst_n = 1; pdn = 0; scnt = W'(3);
    @(negedge clk); chk_all("R2 standby after release", 1, 1, 1);
    @(negedge clk);
    rst_n = 0;
    #1 chk_all("R7 reset in settle", 0, 1, 1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule